// File: doc/BRIEF.md
# Multi-Master Shared Bus Interconnect

This block joins a fixed set of bus masters to a set of slaves over one shared path, all on a single clock. It has three jobs. First, it picks one master to own the bus. Second, it decodes that master's address into a select for at most one slave. Third, it carries the owner's request to the slave side: address, write data, byte lanes, write enable, strobe and a per-slave cycle line. Responses come back from the slaves to the owner over an and-or mux: read data, acknowledge, and the optional error and retry lines. Each slave can answer at up to four address windows. Every window has a base and a power-of-two size. A window whose size field is all ones is switched off.

The strobe/acknowledge pair is the only handshake on the bus. A master asserts strobe and holds its request steady until it sees acknowledge, error or retry. That response is the ready side, and it applies back-pressure directly: nothing is buffered, and every path from request to slave, and from slave response to master, is combinational.

- Ownership is the only state in the block.
- With several masters, a registered grant keeps the current owner on the bus until its cycle line drops.
- With a single master, the arbiter is left out and that master drives the bus directly.
- A parameter chooses whether a slave's select is qualified by the master's cycle line or by its strobe.
- If cycle qualification is chosen, every slave must have a cycle input. Any other setting stops elaboration.
- Byte lanes exist only when the data width is at least twice the granularity. Otherwise a single lane is held high.

Top module: `wbi_shared_bus`

## Requirements
- R1: After reset, with no master asserting its cycle line, no slave sees strobe or cycle, and no master sees acknowledge, error or retry.
- R2: Slave j is matched when the address bits from the top down to bit log2(size) equal the same bits of the base of any of its enabled windows.
- R3: A window whose size field is all ones never matches, even at its own base address.
- R4: In strobe-select mode, a slave's strobe equals match AND the owner's strobe. A slave's cycle line equals match AND the owner's cycle line, but only for slaves built with a cycle input; slaves without one always get 0. With non-overlapping windows, at most one slave strobe is high.
- R5: The byte-lane output carries the owner's DW/GRAN lane bits unchanged. With DW/GRAN = 4, bit k enables byte k.
- R6: When the bus is free, the requesting master with the highest priority value is granted in the same cycle. Ties go to the lower index.
- R7: A granted master keeps the bus for as long as its cycle line stays high. It also keeps the bus in the cycle in which that line falls. Other requests are considered only from the next cycle on.
- R8: Read data is the OR of each readable, selected slave's data. A write-only slave's data never reaches a master.
- R9: Only the owner sees acknowledge, and only as the OR of the acknowledges of the selected slaves.
- R10: Error and retry reach the owner only when that master accepts them and a selected slave that has them enabled asserts them.
- R11: An address that matches no window produces no slave strobe. If any slave has error enabled, an accepting owner then sees error while it strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| m_cyc | input | NM | Cycle line, one per master |
| m_stb | input | NM | Strobe, one per master |
| m_we | input | NM | Write enable, one per master |
| m_adr | input | NM*AW | Addresses, master i at bits i*AW |
| m_dat_w | input | NM*DW | Write data, master i at bits i*DW |
| m_sel | input | NM*LANES | Byte lanes, master i at bits i*LANES |
| m_dat_r | output | DW | Read data, shared by all masters |
| m_ack | output | NM | Acknowledge, one per master |
| m_err | output | NM | Error, one per master |
| m_rty | output | NM | Retry, one per master |
| s_cyc | output | NS | Cycle line to each slave |
| s_stb | output | NS | Strobe to each slave |
| s_we | output | 1 | Shared write enable |
| s_adr | output | AW | Shared address |
| s_dat_w | output | DW | Shared write data |
| s_sel | output | LANES | Shared byte lanes |
| s_dat_r | input | NS*DW | Read data, slave j at bits j*DW |
| s_ack | input | NS | Acknowledge from each slave |
| s_err | input | NS | Error from each slave |
| s_rty | input | NS | Retry from each slave |

## Verification
Every slave-side output and every master-side response is combinational. It is therefore due in the same cycle as the inputs that cause it. The only exception is ownership, which changes one clock edge after the owner's cycle line falls. The bench changes inputs just after the falling edge and compares all outputs a few nanoseconds later, well before the next rising edge. Its reference updates its owner at the rising edge, at the point where the grant register loads. A grant decision therefore shows up in the comparison window of the cycle that follows the edge.

// File: rtl/wbi_pkg.sv
package wbi_pkg;

  // index of the highest set bit (0 for zero)
  function automatic int top_bit(input logic [63:0] v);
    int r;
    r = 0;
    for (int b = 0; b < 64; b++)
      if (v[b]) r = b;
    return r;
  endfunction

  function automatic int ones(input logic [63:0] v);
    int r;
    r = 0;
    for (int b = 0; b < 64; b++)
      if (v[b]) r++;
    return r;
  endfunction

  function automatic int low_bit(input logic [63:0] v);
    int r;
    r = 0;
    for (int b = 63; b >= 0; b--)
      if (v[b]) r = b;
    return r;
  endfunction

endpackage

// File: rtl/wbi_decode.sv
module wbi_decode #(
  parameter int AW   = 16,
  parameter int NS   = 3,
  parameter int NWIN = 4,
  parameter logic [NS*NWIN*AW-1:0] BASES = '0,
  parameter logic [NS*NWIN*AW-1:0] SIZES = '1
) (
  input  logic [AW-1:0] adr,
  output logic [NS-1:0] match
);
  logic [NS*NWIN-1:0] hit;

  for (genvar s = 0; s < NS; s++) begin : g_slv
    for (genvar w = 0; w < NWIN; w++) begin : g_win
      localparam int IDX = s*NWIN + w;
      localparam logic [AW-1:0] SZ = SIZES[IDX*AW +: AW];
      localparam logic [AW-1:0] BS = BASES[IDX*AW +: AW];
      localparam int K = wbi_pkg::top_bit(64'(SZ));
      if (SZ == {AW{1'b1}}) begin : g_off
        assign hit[IDX] = 1'b0;
      end else begin : g_on
        assign hit[IDX] = (((adr ^ BS) >> K) == '0);
      end
    end
    assign match[s] = |hit[s*NWIN +: NWIN];
  end
endmodule

// File: rtl/wbi_arb.sv
module wbi_arb #(
  parameter int NM = 3,
  parameter int PW = 4,
  parameter logic [NM*PW-1:0] PRIO = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NM-1:0] cyc,
  output logic [NM-1:0] gnt
);
  if (NM == 1) begin : g_single
    assign gnt = 1'b1;
  end else begin : g_multi
    logic [NM-1:0] pick, gnt_q;

    always_comb begin
      logic [PW-1:0] bestp;
      logic found;
      int idx;
      pick  = '0;
      bestp = '0;
      found = 1'b0;
      idx   = 0;
      for (int i = 0; i < NM; i++) begin
        if (cyc[i] && (!found || PRIO[i*PW +: PW] > bestp)) begin
          found = 1'b1;
          bestp = PRIO[i*PW +: PW];
          idx   = i;
        end
      end
      if (found) pick[idx] = 1'b1;
    end

    assign gnt = (|gnt_q) ? gnt_q : pick;

    always_ff @(posedge clk) begin
      if (rst) gnt_q <= '0;
      else     gnt_q <= gnt & cyc;
    end

    // R6
    gnt_onehot_chk: assert property (@(posedge clk) disable iff (rst)
      $onehot0(gnt));
    // R7
    owner_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (|(gnt & cyc)) |=> (gnt == $past(gnt)));
  end
endmodule

// File: rtl/wbi_rmux.sv
module wbi_rmux #(
  parameter int NS = 3,
  parameter int DW = 32,
  parameter logic [NS-1:0] READABLE = '1,
  parameter logic [NS-1:0] ERR_EN   = '0,
  parameter logic [NS-1:0] RTY_EN   = '0
) (
  input  logic [NS-1:0]    sel,
  input  logic [NS*DW-1:0] s_dat_r,
  input  logic [NS-1:0]    s_ack,
  input  logic [NS-1:0]    s_err,
  input  logic [NS-1:0]    s_rty,
  output logic [DW-1:0]    dat,
  output logic             ack,
  output logic             err,
  output logic             rty
);
  localparam int NRD   = wbi_pkg::ones(64'(READABLE));
  localparam int FIRST = wbi_pkg::low_bit(64'(READABLE));

  if (NRD == 1) begin : g_pass
    assign dat = s_dat_r[FIRST*DW +: DW];
  end else begin : g_andor
    always_comb begin
      dat = '0;
      for (int j = 0; j < NS; j++)
        dat |= s_dat_r[j*DW +: DW] & {DW{sel[j] & READABLE[j]}};
    end
  end

  assign ack = |(s_ack & sel);
  assign err = |(s_err & sel & ERR_EN);
  assign rty = |(s_rty & sel & RTY_EN);
endmodule

// File: rtl/wbi_shared_bus.sv
module wbi_shared_bus #(
  parameter int NM = 3,
  parameter int NS = 3,
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int GRAN = 8,
  parameter int PW = 4,
  parameter bit SEL_BY_CYC = 1'b0,
  parameter logic [NM*PW-1:0] M_PRIO   = {4'd2, 4'd2, 4'd1},
  parameter logic [NM-1:0]    M_ERR_EN = 3'b101,
  parameter logic [NM-1:0]    M_RTY_EN = 3'b011,
  parameter logic [NS-1:0]    S_HAS_CYC = 3'b011,
  parameter logic [NS-1:0]    S_READ    = 3'b011,
  parameter logic [NS-1:0]    S_ERR_EN  = 3'b001,
  parameter logic [NS-1:0]    S_RTY_EN  = 3'b010,
  parameter logic [NS*4*AW-1:0] WIN_BASE = {
    16'h0000, 16'h0000, 16'h4100, 16'h4000,
    16'h0000, 16'h0000, 16'h6000, 16'h2000,
    16'h0000, 16'h0000, 16'h8000, 16'h0000},
  parameter logic [NS*4*AW-1:0] WIN_SIZE = {
    16'hFFFF, 16'hFFFF, 16'h0010, 16'h0010,
    16'hFFFF, 16'hFFFF, 16'hFFFF, 16'h2000,
    16'hFFFF, 16'hFFFF, 16'h0100, 16'h1000},
  localparam int LANES = (DW >= 2*GRAN) ? DW/GRAN : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NM-1:0]     m_cyc,
  input  logic [NM-1:0]     m_stb,
  input  logic [NM-1:0]     m_we,
  input  logic [NM*AW-1:0]  m_adr,
  input  logic [NM*DW-1:0]  m_dat_w,
  input  logic [NM*LANES-1:0] m_sel,
  output logic [DW-1:0]     m_dat_r,
  output logic [NM-1:0]     m_ack,
  output logic [NM-1:0]     m_err,
  output logic [NM-1:0]     m_rty,
  output logic [NS-1:0]     s_cyc,
  output logic [NS-1:0]     s_stb,
  output logic              s_we,
  output logic [AW-1:0]     s_adr,
  output logic [DW-1:0]     s_dat_w,
  output logic [LANES-1:0]  s_sel,
  input  logic [NS*DW-1:0]  s_dat_r,
  input  logic [NS-1:0]     s_ack,
  input  logic [NS-1:0]     s_err,
  input  logic [NS-1:0]     s_rty
);
  if (SEL_BY_CYC && (S_HAS_CYC != {NS{1'b1}})) begin : g_cfg_bad
    $error("cycle-qualified select needs a cycle input on every slave");
  end

  logic [NM-1:0] gnt;
  logic          bus_cyc, bus_stb;
  logic [NS-1:0] match, slv_sel;
  logic [DW-1:0] r_dat;
  logic          r_ack, r_err, r_rty, nomatch, dflt_err;

  wbi_arb #(.NM(NM), .PW(PW), .PRIO(M_PRIO)) arb_i (
    .clk(clk), .rst(rst), .cyc(m_cyc), .gnt(gnt));

  // and-or request mux, owner selected by the one-hot grant
  always_comb begin
    bus_cyc = 1'b0;
    bus_stb = 1'b0;
    s_we    = 1'b0;
    s_adr   = '0;
    s_dat_w = '0;
    for (int i = 0; i < NM; i++) begin
      bus_cyc |= m_cyc[i] & gnt[i];
      bus_stb |= m_stb[i] & gnt[i];
      s_we    |= m_we[i]  & gnt[i];
      s_adr   |= m_adr[i*AW +: AW]   & {AW{gnt[i]}};
      s_dat_w |= m_dat_w[i*DW +: DW] & {DW{gnt[i]}};
    end
  end

  if (LANES > 1) begin : g_lanes
    always_comb begin
      s_sel = '0;
      for (int i = 0; i < NM; i++)
        s_sel |= m_sel[i*LANES +: LANES] & {LANES{gnt[i]}};
    end
  end else begin : g_nolanes
    assign s_sel = 1'b1;
  end

  wbi_decode #(.AW(AW), .NS(NS), .NWIN(4), .BASES(WIN_BASE), .SIZES(WIN_SIZE))
    dec_i (.adr(s_adr), .match(match));

  if (SEL_BY_CYC) begin : g_cycsel
    assign slv_sel = match & {NS{bus_cyc}};
    assign s_stb   = slv_sel & {NS{bus_stb}};
  end else begin : g_stbsel
    assign slv_sel = match & {NS{bus_stb}};
    assign s_stb   = slv_sel;
  end
  assign s_cyc = match & {NS{bus_cyc}} & S_HAS_CYC;

  wbi_rmux #(.NS(NS), .DW(DW), .READABLE(S_READ), .ERR_EN(S_ERR_EN),
             .RTY_EN(S_RTY_EN)) rmux_i (
    .sel(slv_sel), .s_dat_r(s_dat_r), .s_ack(s_ack), .s_err(s_err),
    .s_rty(s_rty), .dat(r_dat), .ack(r_ack), .err(r_err), .rty(r_rty));

  assign nomatch  = ~|match;
  assign dflt_err = (|S_ERR_EN) & nomatch & bus_cyc & bus_stb;

  assign m_dat_r = r_dat;
  assign m_ack   = gnt & {NM{r_ack}};
  assign m_err   = gnt & M_ERR_EN & {NM{r_err | dflt_err}};
  assign m_rty   = gnt & M_RTY_EN & {NM{r_rty}};

  // R11
  gap_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    nomatch |-> (s_stb == '0));
  // R4
  one_target_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(s_stb));
  // R9
  ack_source_chk: assert property (@(posedge clk) disable iff (rst)
    (|m_ack) |-> (|(s_ack & slv_sel)));
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (m_cyc == '0 && $past(m_cyc) == '0) |-> (s_cyc == '0 && m_ack == '0));
endmodule

// File: tb/wbi_shared_bus_tb.sv
module wbi_shared_bus_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic [2:0]  m_cyc = '0, m_stb = '0, m_we = '0;
  logic [47:0] m_adr = '0;
  logic [95:0] m_dat_w = '0;
  logic [11:0] m_sel = '0;
  logic [31:0] m_dat_r;
  logic [2:0]  m_ack, m_err, m_rty, s_cyc, s_stb;
  logic        s_we;
  logic [15:0] s_adr;
  logic [31:0] s_dat_w;
  logic [3:0]  s_sel;
  logic [95:0] s_dat_r = '0;
  logic [2:0]  s_ack = '0, s_err = '0, s_rty = '0;

  wbi_shared_bus dut_i (
    .clk(clk), .rst(rst), .m_cyc(m_cyc), .m_stb(m_stb), .m_we(m_we),
    .m_adr(m_adr), .m_dat_w(m_dat_w), .m_sel(m_sel), .m_dat_r(m_dat_r),
    .m_ack(m_ack), .m_err(m_err), .m_rty(m_rty), .s_cyc(s_cyc),
    .s_stb(s_stb), .s_we(s_we), .s_adr(s_adr), .s_dat_w(s_dat_w),
    .s_sel(s_sel), .s_dat_r(s_dat_r), .s_ack(s_ack), .s_err(s_err),
    .s_rty(s_rty));

  // reference configuration, written from the requirements
  int prio[3] = '{1, 2, 2};
  bit has_cyc[3] = '{1, 1, 0};
  bit rd_ok[3]   = '{1, 1, 0};
  bit serr[3]    = '{1, 0, 0};
  bit srty[3]    = '{0, 1, 0};
  bit merr[3]    = '{1, 0, 1};
  bit mrty[3]    = '{1, 1, 0};
  int wb[3][4] = '{'{'h0000, 'h8000, 0, 0}, '{'h2000, 'h6000, 0, 0},
                   '{'h4000, 'h4100, 0, 0}};
  int ws[3][4] = '{'{'h1000, 'h0100, 'hFFFF, 'hFFFF},
                   '{'h2000, 'hFFFF, 'hFFFF, 'hFFFF},
                   '{'h0010, 'h0010, 'hFFFF, 'hFFFF}};

  int total = 0, bad = 0, owner = -1;
  bit done = 0;

  function automatic bit win_hit(int j, int a);
    for (int w = 0; w < 4; w++) begin
      if (ws[j][w] == 'hFFFF) continue;
      if (a / ws[j][w] == wb[j][w] / ws[j][w]) return 1'b1;
    end
    return 1'b0;
  endfunction

  function automatic int cur_owner();
    int best;
    if (owner >= 0) return owner;
    best = -1;
    for (int i = 0; i < 3; i++)
      if (m_cyc[i] && (best < 0 || prio[i] > prio[best])) best = i;
    return best;
  endfunction

  always @(posedge clk) begin
    int g;
    if (rst) owner = -1;
    else begin
      g = cur_owner();
      owner = (g >= 0 && m_cyc[g]) ? g : -1;
    end
  end

  task automatic chk(string ph, string nm, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", ph, nm, act, exp);
    end
  endtask

  task automatic tick(string ph);
    int g, a;
    bit c, s, anyhit, ack, err, rty, derr;
    logic [2:0] e_stb, e_cyc, e_ack, e_err, e_rty;
    logic [31:0] e_dat, e_wd;
    logic [3:0] e_sel;
    logic e_we;
    #3;
    g = cur_owner();
    a = 0; c = 0; s = 0; e_we = 0; e_wd = 0; e_sel = 0;
    if (g >= 0) begin
      a = int'(m_adr[g*16 +: 16]); c = m_cyc[g]; s = m_stb[g];
      e_we = m_we[g]; e_wd = m_dat_w[g*32 +: 32]; e_sel = m_sel[g*4 +: 4];
    end
    e_stb = 0; e_cyc = 0; e_dat = 0; anyhit = 0; ack = 0; err = 0; rty = 0;
    for (int j = 0; j < 3; j++) begin
      bit h;
      h = win_hit(j, a);
      anyhit |= h;
      e_stb[j] = h & s;
      e_cyc[j] = h & c & has_cyc[j];
      if (h && s) begin
        if (rd_ok[j]) e_dat |= s_dat_r[j*32 +: 32];
        ack |= s_ack[j];
        err |= s_err[j] & serr[j];
        rty |= s_rty[j] & srty[j];
      end
    end
    derr = !anyhit && c && s;
    e_ack = 0; e_err = 0; e_rty = 0;
    if (g >= 0) begin
      e_ack[g] = ack;
      e_err[g] = (err | derr) & merr[g];
      e_rty[g] = rty & mrty[g];
    end
    chk(ph, "s_stb", 64'(s_stb), 64'(e_stb));
    chk(ph, "s_cyc", 64'(s_cyc), 64'(e_cyc));
    chk(ph, "s_adr", 64'(s_adr), 64'(a[15:0]));
    chk(ph, "s_we", 64'(s_we), 64'(e_we));
    chk(ph, "s_dat_w", 64'(s_dat_w), 64'(e_wd));
    chk(ph, "s_sel", 64'(s_sel), 64'(e_sel));
    chk(ph, "m_dat_r", 64'(m_dat_r), 64'(e_dat));
    chk(ph, "m_ack", 64'(m_ack), 64'(e_ack));
    chk(ph, "m_err", 64'(m_err), 64'(e_err));
    chk(ph, "m_rty", 64'(m_rty), 64'(e_rty));
    @(negedge clk);
  endtask

  task automatic mset(int i, bit c, bit s, bit w, int a, int d, int sl);
    m_cyc[i] = c; m_stb[i] = s; m_we[i] = w;
    m_adr[i*16 +: 16] = a[15:0];
    m_dat_w[i*32 +: 32] = d;
    m_sel[i*4 +: 4] = sl[3:0];
  endtask

  task automatic idle_all();
    for (int i = 0; i < 3; i++) mset(i, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    tick("R1 idle");
    tick("R1 idle");
    s_dat_r = {32'hDEAD_BEEF, 32'h1111_2222, 32'h3333_4444};
    s_ack = 3'b111;
    mset(0, 1, 1, 1, 'h0123, 'hA5A5_0001, 'hF); tick("R2 slave0 win0");
    mset(0, 1, 1, 0, 'h8042, 'hA5A5_0002, 'h3); tick("R2 slave0 win1");
    mset(0, 1, 1, 0, 'h2FFF, 'hA5A5_0003, 'h1); tick("R2 slave1 top");
    mset(0, 1, 1, 1, 'h400F, 'hA5A5_0004, 'h8); tick("R2 slave2 win0");
    mset(0, 1, 1, 1, 'h410A, 'hA5A5_0005, 'h2); tick("R2 slave2 win1");
    mset(0, 1, 1, 0, 'h8100, 0, 'hF); tick("R2 past win1");
    mset(0, 1, 1, 0, 'h6000, 0, 'hF); tick("R3 disabled window");
    mset(0, 1, 1, 0, 'h1000, 0, 'hF); tick("R11 gap error m0");
    idle_all(); tick("R1 release");
    mset(0, 1, 0, 0, 'h0010, 0, 0); tick("R4 cyc without stb");
    mset(0, 1, 0, 0, 'h4000, 0, 0); tick("R4 no cyc input");
    mset(0, 1, 1, 1, 'h4004, 7, 'h6); tick("R5 lanes 0110");
    mset(0, 1, 1, 1, 'h0004, 9, 'h9); tick("R5 lanes 1001");
    idle_all(); tick("R1 release");
    mset(1, 1, 1, 0, 'h0100, 1, 'hF); mset(2, 1, 1, 0, 'h2100, 2, 'hF);
    tick("R6 tie lower index");
    idle_all(); tick("R6 release");
    mset(0, 1, 1, 0, 'h0100, 1, 'hF); mset(2, 1, 1, 0, 'h2100, 2, 'hF);
    tick("R6 higher priority");
    idle_all(); tick("R6 release");
    mset(0, 1, 1, 0, 'h0100, 1, 'hF); mset(1, 1, 1, 0, 'h2200, 3, 'h1);
    mset(2, 1, 1, 0, 'h2100, 2, 'hF); tick("R6 three way");
    idle_all(); tick("R6 release");
    mset(0, 1, 1, 1, 'h0200, 5, 'hF); tick("R7 owner m0");
    mset(2, 1, 1, 0, 'h2100, 2, 'hF); tick("R7 hold vs m2");
    tick("R7 hold vs m2");
    mset(0, 0, 0, 0, 'h0200, 0, 0); tick("R7 cycle drop");
    tick("R7 handover");
    idle_all(); tick("R1 release");
    s_err = 3'b111; s_rty = 3'b111;
    mset(0, 1, 1, 0, 'h0300, 0, 'hF); tick("R10 err m0 slave0");
    idle_all(); tick("R10 release");
    mset(1, 1, 1, 0, 'h0300, 0, 'hF); tick("R10 err m1 refuses");
    mset(1, 1, 1, 0, 'h2300, 0, 'hF); tick("R10 rty m1 slave1");
    idle_all(); tick("R10 release");
    mset(2, 1, 1, 0, 'h2300, 0, 'hF); tick("R10 rty m2 refuses");
    mset(2, 1, 1, 0, 'h1800, 0, 'hF); tick("R11 gap error m2");
    idle_all(); tick("R11 release");
    mset(1, 1, 1, 0, 'h1800, 0, 'hF); tick("R11 gap m1 no err");
    idle_all(); tick("R8 release");
    s_err = 0; s_rty = 0;
    mset(0, 1, 1, 0, 'h4002, 0, 'hF); tick("R8 write-only data");
    s_ack = 3'b110;
    mset(0, 1, 1, 0, 'h0002, 0, 'hF); tick("R9 ack from unselected");
    idle_all(); tick("R9 release");
    for (int n = 0; n < 400; n++) begin
      int adrs[8] = '{'h0010, 'h80FF, 'h2345, 'h400C, 'h4109, 'h6000, 'h1234, 'hF000};
      for (int i = 0; i < 3; i++)
        mset(i, ($urandom % 4) != 0, $urandom % 2, $urandom % 2,
             adrs[$urandom % 8], int'($urandom), int'($urandom % 16));
      s_dat_r = {$urandom, $urandom, $urandom};
      s_ack = 3'($urandom); s_err = 3'($urandom); s_rty = 3'($urandom);
      tick("R9 R10 mixed traffic");
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule